// File: doc/BRIEF.md
# GPIO Controller with Peripheral Pin Muxing

This block is a register-mapped general-purpose I/O controller for 32 pins, split into two banks of 16. Software writes output levels and drive enables per bank, and reads back the synchronised pin levels through separate input registers. A control register lets two serial peripherals claim fixed pin groups: a high-speed serial port on pins 15 to 12 and an SPI slave port on pins 11 to 8. A select-override bit moves the SPI slave-select input onto pin 15. This takes precedence over the serial port's use of that pin, and it frees pin 11 for plain GPIO.

One pin, chosen by a parameter and pin 0 by default, feeds an edge-triggered interrupt. Its polarity is selectable. It is armed only when both a local enable in the control register and a global enable in a separate interrupt-enable register are set. A detected edge sets a sticky status bit, and writing 1 to that bit clears it. The register bus is a plain one: a byte address, a write strobe, 16-bit write data and combinational 16-bit read data.

Word addresses (hex): control 1C, bank-0 output 1E, bank-0 direction 20, bank-1 direction 22, bank-1 output 24, bank-0 input 28, bank-1 input 2A, interrupt enable 2C, interrupt status 2E.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every output, direction, control, enable and status register reads 0, pin_o and pin_oe_o are all 0, and irq_o is 0.
- R2: A write to the bank-0 output register (1E) is read back unchanged. Each pin_o[15:0] bit that is not claimed by a peripheral equals the stored bit, and the matching pin_oe_o bit equals the bank-0 direction register (20) bit.
- R3: The bank-1 output register (24) and bank-1 direction register (22) store only the bits in mask E1F8. Bits 12..9 and 2..0 read as 0, and pins 28..25 and 18..16 never drive (pin_o and pin_oe_o are 0 there).
- R4: Reading an output register returns the stored value, not the pin level. The input registers (28 for pins 15..0, 2A for pins 31..16) show a pin change two clock edges after it happens, and still show the old level after one edge.
- R5: With control bit 7 set, pin 12 drives hss_txd_i and pin 14 drives hss_rts_i, both with the drive enable on. Pins 13 and 15 do not drive, and their levels appear on hss_rxd_o and hss_cts_o. With bit 7 clear, pins 15..12 are GPIO and hss_rxd_o and hss_cts_o are 1.
- R6: With control bit 5 set, pin 10 drives spi_miso_i with the drive enable on. Pins 8, 9 and 11 do not drive, and they feed spi_sck_o, spi_mosi_o and spi_ss_n_o. With bit 5 clear, pins 11..8 are GPIO, spi_sck_o and spi_mosi_o are 0, and spi_ss_n_o is 1.
- R7: With control bits 5 and 4 both set, spi_ss_n_o follows pin 15 and pin 15 does not drive, even when bit 7 is set. Pin 11 then behaves as GPIO.
- R8: Control bit 1 selects the interrupt edge: 1 for rising, 0 for falling. The status bit is set on the third clock edge after the pin change, and an edge of the other polarity has no effect.
- R9: An edge sets the status bit, and irq_o is high, only when control bit 0 and interrupt-enable register (2C) bit 0 are both 1. irq_o is the status bit gated by both enables.
- R10: Status bit 0 at 2E stays set until a write with data bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R11: Reads from unmapped addresses return 0, and writes to them change no register.
- R12: Control register bits other than 7, 5, 4, 1 and 0 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational from addr_i) |
| pin_i | input | 32 | Pin levels from the pads |
| pin_o | output | 32 | Pin output levels |
| pin_oe_o | output | 32 | Pin drive enables |
| hss_txd_i | input | 1 | Serial port transmit data |
| hss_rts_i | input | 1 | Serial port request-to-send |
| hss_rxd_o | output | 1 | Serial port receive data |
| hss_cts_o | output | 1 | Serial port clear-to-send |
| spi_miso_i | input | 1 | SPI slave data out |
| spi_sck_o | output | 1 | SPI clock to the slave |
| spi_mosi_o | output | 1 | SPI data to the slave |
| spi_ss_n_o | output | 1 | SPI slave select, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes take effect at the clock edge that captures them, so the bench reads them back at the following falling edge. Pin muxing and peripheral routing are combinational and are sampled 1 ns after a falling-edge input change. The input registers lag the pins by two edges, and the bench checks the old value after one edge and the new value after two. The interrupt status lags by three edges: two in the synchroniser and one in the status register. The bench checks irq_o low after the second edge following the pin change and high after the third.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int BANK_W = 16;

  localparam logic [7:0] ADR_CTRL = 8'h1C;
  localparam logic [7:0] ADR_OUT0 = 8'h1E;
  localparam logic [7:0] ADR_DIR0 = 8'h20;
  localparam logic [7:0] ADR_DIR1 = 8'h22;
  localparam logic [7:0] ADR_OUT1 = 8'h24;
  localparam logic [7:0] ADR_IN0  = 8'h28;
  localparam logic [7:0] ADR_IN1  = 8'h2A;
  localparam logic [7:0] ADR_IEN  = 8'h2C;
  localparam logic [7:0] ADR_ISTS = 8'h2E;

  localparam int CB_HSS = 7;
  localparam int CB_SPI = 5;
  localparam int CB_OVR = 4;
  localparam int CB_POL = 1;
  localparam int CB_LEN = 0;

  localparam logic [BANK_W-1:0] CTRL_MASK  = 16'h00B3;
  localparam logic [BANK_W-1:0] BANK1_MASK = 16'hE1F8;

  localparam int P_SCK    = 8;
  localparam int P_MOSI   = 9;
  localparam int P_MISO   = 10;
  localparam int P_SS     = 11;
  localparam int P_TXD    = 12;
  localparam int P_RXD    = 13;
  localparam int P_RTS    = 14;
  localparam int P_CTS    = 15;
  localparam int P_SS_ALT = 15;

  typedef struct packed {
    logic hss_en;
    logic spi_en;
    logic ovr_en;
    logic pol_rise;
    logic loc_en;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [BANK_W-1:0] r);
    ctrl_t c;
    c.hss_en   = r[CB_HSS];
    c.spi_en   = r[CB_SPI];
    c.ovr_en   = r[CB_OVR];
    c.pol_rise = r[CB_POL];
    c.loc_en   = r[CB_LEN];
    return c;
  endfunction

  function automatic logic [BANK_W-1:0] bank_mask(input int b);
    return (b == 0) ? {BANK_W{1'b1}} : BANK1_MASK;
  endfunction

  function automatic logic [7:0] out_addr(input int b);
    return (b == 0) ? ADR_OUT0 : ADR_OUT1;
  endfunction

  function automatic logic [7:0] dir_addr(input int b);
    return (b == 0) ? ADR_DIR0 : ADR_DIR1;
  endfunction

  function automatic logic [7:0] in_addr(input int b);
    return (b == 0) ? ADR_IN0 : ADR_IN1;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 8,
  localparam int NPINS = NBANK * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [NPINS-1:0]  in_sync_i,
  input  logic              sts_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic [NPINS-1:0]  out_q_o,
  output logic [NPINS-1:0]  dir_q_o,
  output ctrl_t             cfg_o,
  output logic              glb_en_o,
  output logic              sts_clr_o
);
  logic [BANK_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_we;
  logic              glb_q, glb_d, glb_we;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BANK_W-1:0] out_q, out_d, dir_q, dir_d;
    logic              out_we, dir_we;

    always_comb begin
      out_we = wr_en_i && (addr_i == ADDR_W'(out_addr(b)));
      dir_we = wr_en_i && (addr_i == ADDR_W'(dir_addr(b)));
      out_d  = wdata_i & bank_mask(b);
      dir_d  = wdata_i & bank_mask(b);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q <= '0;
        dir_q <= '0;
      end else begin
        if (out_we) out_q <= out_d;
        if (dir_we) dir_q <= dir_d;
      end
    end

    assign out_q_o[b*BANK_W +: BANK_W] = out_q;
    assign dir_q_o[b*BANK_W +: BANK_W] = dir_q;
  end

  always_comb begin
    ctrl_we   = wr_en_i && (addr_i == ADDR_W'(ADR_CTRL));
    ctrl_d    = wdata_i & CTRL_MASK;
    glb_we    = wr_en_i && (addr_i == ADDR_W'(ADR_IEN));
    glb_d     = wdata_i[0];
    sts_clr_o = wr_en_i && (addr_i == ADDR_W'(ADR_ISTS)) && wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      glb_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (glb_we)  glb_q  <= glb_d;
    end
  end

  assign cfg_o    = decode_ctrl(ctrl_q);
  assign glb_en_o = glb_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_CTRL)) rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(ADR_IEN))  rdata_o = {{(BANK_W-1){1'b0}}, glb_q};
    if (addr_i == ADDR_W'(ADR_ISTS)) rdata_o = {{(BANK_W-1){1'b0}}, sts_i};
    for (int b = 0; b < NBANK; b++) begin
      if (addr_i == ADDR_W'(out_addr(b))) rdata_o = out_q_o[b*BANK_W +: BANK_W];
      if (addr_i == ADDR_W'(dir_addr(b))) rdata_o = dir_q_o[b*BANK_W +: BANK_W];
      if (addr_i == ADDR_W'(in_addr(b)))  rdata_o = in_sync_i[b*BANK_W +: BANK_W];
    end
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  ctrl_t            cfg_i,
  input  logic [NPINS-1:0] gpio_o_i,
  input  logic [NPINS-1:0] gpio_oe_i,
  input  logic             sck_pin_i,
  input  logic             mosi_pin_i,
  input  logic             ss_pin_i,
  input  logic             ss_alt_pin_i,
  input  logic             rxd_pin_i,
  input  logic             cts_pin_i,
  input  logic             hss_txd_i,
  input  logic             hss_rts_i,
  input  logic             spi_miso_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic             hss_rxd_o,
  output logic             hss_cts_o,
  output logic             spi_sck_o,
  output logic             spi_mosi_o,
  output logic             spi_ss_n_o
);
  always_comb begin
    pin_o      = gpio_o_i;
    pin_oe_o   = gpio_oe_i;
    hss_rxd_o  = 1'b1;
    hss_cts_o  = 1'b1;
    spi_sck_o  = 1'b0;
    spi_mosi_o = 1'b0;
    spi_ss_n_o = 1'b1;

    if (cfg_i.hss_en) begin
      pin_o[P_TXD]    = hss_txd_i;
      pin_oe_o[P_TXD] = 1'b1;
      pin_o[P_RTS]    = hss_rts_i;
      pin_oe_o[P_RTS] = 1'b1;
      pin_o[P_RXD]    = 1'b0;
      pin_oe_o[P_RXD] = 1'b0;
      pin_o[P_CTS]    = 1'b0;
      pin_oe_o[P_CTS] = 1'b0;
      hss_rxd_o       = rxd_pin_i;
      hss_cts_o       = cts_pin_i;
    end

    if (cfg_i.spi_en) begin
      pin_o[P_SCK]     = 1'b0;
      pin_oe_o[P_SCK]  = 1'b0;
      pin_o[P_MOSI]    = 1'b0;
      pin_oe_o[P_MOSI] = 1'b0;
      pin_o[P_MISO]    = spi_miso_i;
      pin_oe_o[P_MISO] = 1'b1;
      spi_sck_o        = sck_pin_i;
      spi_mosi_o       = mosi_pin_i;
      if (cfg_i.ovr_en) begin
        pin_o[P_SS_ALT]    = 1'b0;
        pin_oe_o[P_SS_ALT] = 1'b0;
        spi_ss_n_o         = ss_alt_pin_i;
      end else begin
        pin_o[P_SS]    = 1'b0;
        pin_oe_o[P_SS] = 1'b0;
        spi_ss_n_o     = ss_pin_i;
      end
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_mux_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  ctrl_t cfg_i,
  input  logic  glb_en_i,
  input  logic  clr_i,
  output logic  sts_o,
  output logic  irq_o
);
  logic prev_q, sts_q, sts_d;
  logic rise, fall, hit, armed;

  always_comb begin
    rise  = lvl_i & ~prev_q;
    fall  = ~lvl_i & prev_q;
    hit   = cfg_i.pol_rise ? rise : fall;
    armed = cfg_i.loc_en & glb_en_i;
    sts_d = (sts_q & ~clr_i) | (hit & armed);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      sts_q  <= sts_d;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & armed;
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int NBANK       = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_PIN     = 0,
  localparam int NPINS      = NBANK * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  input  logic              hss_txd_i,
  input  logic              hss_rts_i,
  output logic              hss_rxd_o,
  output logic              hss_cts_o,
  input  logic              spi_miso_i,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  output logic              spi_ss_n_o,
  output logic              irq_o
);
  logic [NPINS-1:0] in_sync, out_q, dir_q;
  ctrl_t            cfg;
  logic             glb_en, sts_clr, irq_sts;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(in_sync)
  );

  gpio_regs #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .in_sync_i(in_sync),
    .sts_i    (irq_sts),
    .rdata_o  (rdata_o),
    .out_q_o  (out_q),
    .dir_q_o  (dir_q),
    .cfg_o    (cfg),
    .glb_en_o (glb_en),
    .sts_clr_o(sts_clr)
  );

  gpio_pinmux #(.NPINS(NPINS)) u_mux (
    .cfg_i       (cfg),
    .gpio_o_i    (out_q),
    .gpio_oe_i   (dir_q),
    .sck_pin_i   (pin_i[P_SCK]),
    .mosi_pin_i  (pin_i[P_MOSI]),
    .ss_pin_i    (pin_i[P_SS]),
    .ss_alt_pin_i(pin_i[P_SS_ALT]),
    .rxd_pin_i   (pin_i[P_RXD]),
    .cts_pin_i   (pin_i[P_CTS]),
    .hss_txd_i   (hss_txd_i),
    .hss_rts_i   (hss_rts_i),
    .spi_miso_i  (spi_miso_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o),
    .hss_rxd_o   (hss_rxd_o),
    .hss_cts_o   (hss_cts_o),
    .spi_sck_o   (spi_sck_o),
    .spi_mosi_o  (spi_mosi_o),
    .spi_ss_n_o  (spi_ss_n_o)
  );

  gpio_edge_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (in_sync[IRQ_PIN]),
    .cfg_i   (cfg),
    .glb_en_i(glb_en),
    .clr_i   (sts_clr),
    .sts_o   (irq_sts),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/gpio_mux_ctrl_chk.sv
module gpio_mux_ctrl_chk
  import gpio_mux_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  addr_i,
  input logic        wr_en_i,
  input logic        wdata0,
  input logic [31:0] pin_o,
  input logic [31:0] pin_oe_o,
  input logic        ss_alt_pin,
  input logic        spi_ss_n_o,
  input logic        irq_o,
  input ctrl_t       cfg,
  input logic        glb_en,
  input logic        sts_q
);
  // R1: quiet outputs while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_o == '0 && pin_oe_o == '0 && !irq_o));

  // R3: pins with no storage never drive
  a_r3_no_storage_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o[28:25] == 4'h0 && pin_oe_o[28:25] == 4'h0 &&
     pin_o[18:16] == 3'h0 && pin_oe_o[18:16] == 3'h0));

  // R5: receive pin is never driven while the serial port owns it
  a_r5_rxd_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.hss_en |-> !pin_oe_o[P_RXD]);

  // R7: select override takes pin 15 as input
  a_r7_ss_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.spi_en && cfg.ovr_en) |-> (spi_ss_n_o == ss_alt_pin && !pin_oe_o[P_SS_ALT]));

  // R9: interrupt only with both enables
  a_r9_two_level_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cfg.loc_en && glb_en));

  // R10: status is sticky until a write-one clear
  a_r10_sticky_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !(wr_en_i && addr_i == ADR_ISTS && wdata0)) |=> sts_q);
endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata0    (wdata_i[0]),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .ss_alt_pin(pin_i[15]),
  .spi_ss_n_o(spi_ss_n_o),
  .irq_o     (irq_o),
  .cfg       (cfg),
  .glb_en    (glb_en),
  .sts_q     (irq_sts)
);

// File: tb/sim_gpio_mux_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_mux_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  addr_i;
  logic        wr_en_i;
  logic [15:0] wdata_i;
  logic [15:0] rdata_o;
  logic [31:0] pin_i, pin_o, pin_oe_o;
  logic        hss_txd_i, hss_rts_i, hss_rxd_o, hss_cts_o;
  logic        spi_miso_i, spi_sck_o, spi_mosi_o, spi_ss_n_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_mux_ctrl u0 (.*);

  // {address, write data, expected readback}
  localparam logic [39:0] VEC [8] = '{
    {8'h1E, 16'hA5C3, 16'hA5C3},  // R2
    {8'h1E, 16'hFFFF, 16'hFFFF},  // R2
    {8'h24, 16'hFFFF, 16'hE1F8},  // R3
    {8'h24, 16'h1E07, 16'h0000},  // R3
    {8'h1C, 16'hFFFF, 16'h00B3},  // R12
    {8'h1C, 16'h0000, 16'h0000},  // R12
    {8'h30, 16'hFFFF, 16'h0000},  // R11
    {8'h24, 16'hA5A5, 16'hA1A0}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pin0(input logic v);
    @(negedge clk_i);
    pin_i[0] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_ni = 1'b0; addr_i = '0; wr_en_i = 1'b0; wdata_i = '0; pin_i = '0;
    hss_txd_i = 1'b0; hss_rts_i = 1'b0; spi_miso_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 pin_oe in reset", pin_oe_o, 32'h0);
    check("R1 irq in reset", {31'h0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    rd(8'h1E, d); check("R1 out0 after reset", {16'h0, d}, 32'h0);
    rd(8'h2E, d); check("R1 status after reset", {16'h0, d}, 32'h0);
    check("R1 pin_o after reset", pin_o, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][39:32], VEC[i][31:16]);
      rd(VEC[i][39:32], d);
      check("R2/R3/R11/R12 table readback", {16'h0, d}, {16'h0, VEC[i][15:0]});
    end
    rd(8'h1E, d); check("R11 unmapped write left out0", {16'h0, d}, 32'h0000FFFF);

    // R2 pin drive
    wr(8'h20, 16'hFFFF); wr(8'h1E, 16'hA5C3);
    #1 check("R2 pin_o bank0", {16'h0, pin_o[15:0]}, 32'h0000A5C3);
    check("R2 pin_oe bank0", {16'h0, pin_oe_o[15:0]}, 32'h0000FFFF);
    // R3 bank1 pins
    wr(8'h22, 16'hFFFF); wr(8'h24, 16'hFFFF);
    #1 check("R3 pin_o bank1", {16'h0, pin_o[31:16]}, 32'h0000E1F8);
    check("R3 pin_oe bank1", {16'h0, pin_oe_o[31:16]}, 32'h0000E1F8);
    rd(8'h22, d); check("R3 dir1 readback", {16'h0, d}, 32'h0000E1F8);

    // R4 input path latency
    @(negedge clk_i); pin_i[15:0] = 16'h1234; addr_i = 8'h28;
    @(negedge clk_i); #1 check("R4 input after one edge", {16'h0, rdata_o}, 32'h0);
    @(negedge clk_i); #1 check("R4 input after two edges", {16'h0, rdata_o}, 32'h00001234);
    rd(8'h1E, d); check("R4 out0 returns stored not pins", {16'h0, d}, 32'h0000A5C3);
    @(negedge clk_i); pin_i[31:16] = 16'h8001; addr_i = 8'h2A;
    repeat (2) @(negedge clk_i);
    #1 check("R4 input bank1", {16'h0, rdata_o}, 32'h00008001);
    @(negedge clk_i); pin_i = '0;

    // R5 serial port routing
    check("R5 rxd idle when off", {31'h0, hss_rxd_o}, 32'h1);
    wr(8'h1C, 16'h0080);
    hss_txd_i = 1'b1; hss_rts_i = 1'b0; pin_i[13] = 1'b0; pin_i[15] = 1'b1;
    #1 check("R5 pin12 txd", {31'h0, pin_o[12]}, 32'h1);
    check("R5 pin14 rts", {31'h0, pin_o[14]}, 32'h0);
    check("R5 oe 15..12", {28'h0, pin_oe_o[15:12]}, 32'h5);
    check("R5 rxd/cts from pins", {30'h0, hss_rxd_o, hss_cts_o}, 32'h1);
    check("R5 pins 11..8 stay GPIO", {24'h0, pin_oe_o[11:8], pin_o[11:8]}, 32'hF5);
    wr(8'h1C, 16'h0000);
    #1 check("R5 off: oe 15..12 GPIO", {28'h0, pin_oe_o[15:12]}, 32'hF);
    check("R5 off: rxd/cts idle", {30'h0, hss_rxd_o, hss_cts_o}, 32'h3);
    pin_i = '0;

    // R6 SPI routing
    check("R6 off idle sck/mosi/ss", {29'h0, spi_sck_o, spi_mosi_o, spi_ss_n_o}, 32'h1);
    wr(8'h1C, 16'h0020);
    spi_miso_i = 1'b1; pin_i[8] = 1'b1; pin_i[9] = 1'b0; pin_i[11] = 1'b0;
    #1 check("R6 pin10 miso", {31'h0, pin_o[10]}, 32'h1);
    check("R6 oe 11..8", {28'h0, pin_oe_o[11:8]}, 32'h4);
    check("R6 sck/mosi/ss from pins", {29'h0, spi_sck_o, spi_mosi_o, spi_ss_n_o}, 32'h4);

    // R7 select override, serial port also on
    wr(8'h1C, 16'h00B0);
    pin_i[15] = 1'b0; pin_i[11] = 1'b1;
    #1 check("R7 ss from pin15 low", {31'h0, spi_ss_n_o}, 32'h0);
    check("R7 pin15 not driven, pin11 GPIO", {29'h0, pin_oe_o[15], pin_oe_o[11], pin_o[11]}, 32'h2);
    @(negedge clk_i); pin_i[15] = 1'b1;
    #1 check("R7 ss from pin15 high", {31'h0, spi_ss_n_o}, 32'h1);
    wr(8'h1C, 16'h0000); pin_i = '0;

    // R8 / R9 / R10 interrupt
    wr(8'h2C, 16'h0001); wr(8'h1C, 16'h0003);
    repeat (4) @(negedge clk_i);
    wr(8'h2E, 16'h0001);
    pin0(1'b1);
    repeat (2) @(negedge clk_i);
    #1 check("R8 irq not yet after two edges", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i); #1 check("R8 rising edge irq on third edge", {31'h0, irq_o}, 32'h1);
    wr(8'h2E, 16'h0000);
    #1 check("R10 write 0 keeps status", {31'h0, irq_o}, 32'h1);
    wr(8'h2E, 16'h0001);
    #1 check("R10 write 1 clears status", {31'h0, irq_o}, 32'h0);
    pin0(1'b0);
    repeat (5) @(negedge clk_i);
    rd(8'h2E, d); check("R8 falling edge ignored in rising mode", {16'h0, d}, 32'h0);
    wr(8'h1C, 16'h0001);
    pin0(1'b1);
    repeat (5) @(negedge clk_i);
    #1 check("R8 rising edge ignored in falling mode", {31'h0, irq_o}, 32'h0);
    pin0(1'b0);
    repeat (3) @(negedge clk_i);
    #1 check("R8 falling edge irq", {31'h0, irq_o}, 32'h1);
    wr(8'h2E, 16'h0001);
    // R9 global enable off
    wr(8'h2C, 16'h0000); wr(8'h1C, 16'h0003);
    pin0(1'b1);
    repeat (5) @(negedge clk_i);
    rd(8'h2E, d); check("R9 no status without global enable", {15'h0, d[0], irq_o}, 32'h0);
    // R9 local enable off
    wr(8'h2C, 16'h0001); wr(8'h1C, 16'h0002);
    pin0(1'b0);
    repeat (4) @(negedge clk_i);
    pin0(1'b1);
    repeat (5) @(negedge clk_i);
    rd(8'h2E, d); check("R9 no status without local enable", {15'h0, d[0], irq_o}, 32'h0);
    rd(8'h2C, d); check("R9 global enable readback", {16'h0, d}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule